// File: doc/BRIEF.md
# Power-Management I/O Window Configuration Decoder

This block holds the device-specific part (offsets 0x40 to 0xFF) of a power-management function's configuration space. It is organised as dwords and takes byte-enabled writes. Two of these dwords are I/O base registers. One places a 128-byte power-management window and the other places a 16-byte SMBus window. Each window is switched on by its own enable bit, and each enable bit lives in a different configuration byte.

Every write is cleaned before it is stored. A base register keeps only the address bits that its window alignment allows, and it always reads back with bit 0 set. The SMBus enable byte keeps only its low nibble. An incoming 16-bit I/O address is compared against both windows, and the block raises one hit signal per window. If the two windows overlap, the power-management window wins. A change to a base or an enable affects decoding from the cycle after the write.

Top module: `iowin_cfg_decoder`

## Requirements
- R1: After reset, every dword at 0x40 to 0xFC reads 0x00000000, except dwords 0x48 and 0x90, which read 0x00000001. Both hit outputs are low while reset leaves the windows disabled.
- R2: A write to dword 0x48 with at least one byte lane enabled stores the lane-merged value ANDed with 0x0000FF80, with bit 0 then set to 1.
- R3: A write to dword 0x90 with at least one byte lane enabled stores the lane-merged value ANDed with 0x0000FFF0, with bit 0 then set to 1.
- R4: Byte 0xD2 (dword 0xD0, bits 23:16) keeps only its low 4 bits when written. The other lanes of that dword store their data unchanged.
- R5: Only the lanes selected by cfg_be (bit k covers bits 8k+7:8k) are updated. A write with cfg_be of 0 leaves the dword unchanged.
- R6: All other dwords from 0x40 to 0xFC store every enabled byte in full and read it back unchanged.
- R7: pm_hit is high exactly when bit 7 of byte 0x41 (dword 0x40, bit 15) is set and io_addr[15:7] equals bits 15:7 of the power-management base.
- R8: smb_hit is high exactly when bit 0 of byte 0xD2 (dword 0xD0, bit 16) is set, io_addr[15:4] equals bits 15:4 of the SMBus base, and pm_hit is low. The two hits are never high together.
- R9: Dwords 0x00 to 0x3C, which form the standard header, are not stored here. Writes to them are ignored and they read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | 6 | Dword index of the write (byte offset / 4) |
| cfg_be | input | 4 | Byte-lane enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 6 | Dword index of the combinational read |
| cfg_rdata | output | 32 | Read data |
| io_addr | input | 16 | I/O address to decode |
| pm_hit | output | 1 | Address falls in the enabled power-management window |
| smb_hit | output | 1 | Address falls in the enabled SMBus window and not in the PM window |

## Verification
The bench builds the block with its default parameters: a 16-bit I/O space, a 128-byte and a 16-byte window, and a 64-dword configuration space. With these values the bench can write every device-specific dword under all sixteen byte-enable patterns, each followed by a readback. It can also sweep the complete 64K I/O address space for one window placement. Further partial sweeps cover windows that overlap, windows that are disabled, and a window that has been moved.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  typedef logic [31:0] cfg_dword_t;

  // Address bits kept by a base register for a window of 2**win_log2 bytes
  function automatic cfg_dword_t win_keep(input int io_w, input int win_log2);
    cfg_dword_t m;
    m = '0;
    for (int b = 0; b < 32; b++) begin
      if (b < io_w && b >= win_log2) m[b] = 1'b1;
    end
    return m;
  endfunction

  // Keep mask for a dword holding one byte restricted to byte_keep
  function automatic cfg_dword_t byte_keep(input int lane, input logic [7:0] keep);
    cfg_dword_t m;
    m = '1;
    for (int b = 0; b < 8; b++) m[lane*8+b] = keep[b];
    return m;
  endfunction
endpackage

// File: rtl/cfg_dword_reg.sv
module cfg_dword_reg
  import iowin_pkg::*;
#(
  parameter cfg_dword_t KEEP  = '1,
  parameter cfg_dword_t FORCE = '0,
  parameter cfg_dword_t RESET = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] be,
  input  cfg_dword_t wdata,
  output cfg_dword_t q
);
  cfg_dword_t merged;
  cfg_dword_t q_d;
  logic       load;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      merged[k*8 +: 8] = be[k] ? wdata[k*8 +: 8] : q[k*8 +: 8];
    end
    load = wr_en && (be != 4'b0000);
    q_d  = (merged & KEEP) | FORCE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RESET;
    else if (load) q <= q_d;
  end

  // Lanes without an enable keep their contents across a write
  for (genvar k = 0; k < 4; k++) begin : g_lane_chk
    assert_lane_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !be[k]) |=> $stable(q[k*8 +: 8]));
  end
endmodule

// File: rtl/iowin_match.sv
module iowin_match #(
  parameter int IO_W     = 16,
  parameter int WIN_LOG2 = 7
) (
  input  logic [IO_W-1:0] io_addr,
  input  logic [IO_W-1:0] base,
  input  logic            enable,
  output logic            hit
);
  always_comb begin
    hit = enable && (io_addr[IO_W-1:WIN_LOG2] == base[IO_W-1:WIN_LOG2]);
  end
endmodule

// File: rtl/iowin_cfg_decoder.sv
module iowin_cfg_decoder
  import iowin_pkg::*;
#(
  parameter int         IO_W         = 16,
  parameter int         PM_WIN_LOG2  = 7,
  parameter int         SMB_WIN_LOG2 = 4,
  parameter int         CFG_DWORDS   = 64,
  parameter int         DEV_FIRST    = 'h40,
  parameter int         PM_BASE_OFS  = 'h48,
  parameter int         PM_EN_OFS    = 'h41,
  parameter int         PM_EN_BIT    = 7,
  parameter int         SMB_BASE_OFS = 'h90,
  parameter int         SMB_EN_OFS   = 'hD2,
  parameter int         SMB_EN_BIT   = 0,
  parameter logic [7:0] SMB_EN_KEEP  = 8'h0F
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [$clog2(CFG_DWORDS)-1:0] cfg_waddr,
  input  logic [3:0]                    cfg_be,
  input  logic [31:0]                   cfg_wdata,
  input  logic [$clog2(CFG_DWORDS)-1:0] cfg_raddr,
  output logic [31:0]                   cfg_rdata,
  input  logic [IO_W-1:0]               io_addr,
  output logic                          pm_hit,
  output logic                          smb_hit
);
  localparam int         FIRST_DW    = DEV_FIRST / 4;
  localparam int         PM_BASE_DW  = PM_BASE_OFS / 4;
  localparam int         SMB_BASE_DW = SMB_BASE_OFS / 4;
  localparam int         PM_EN_DW    = PM_EN_OFS / 4;
  localparam int         PM_EN_POS   = (PM_EN_OFS % 4) * 8 + PM_EN_BIT;
  localparam int         SMB_EN_DW   = SMB_EN_OFS / 4;
  localparam int         SMB_EN_LANE = SMB_EN_OFS % 4;
  localparam int         SMB_EN_POS  = SMB_EN_LANE * 8 + SMB_EN_BIT;
  localparam cfg_dword_t PM_KEEP     = win_keep(IO_W, PM_WIN_LOG2);
  localparam cfg_dword_t SMB_KEEP    = win_keep(IO_W, SMB_WIN_LOG2);
  localparam cfg_dword_t SEN_KEEP    = byte_keep(SMB_EN_LANE, SMB_EN_KEEP);
  localparam cfg_dword_t BASE_FORCE  = 32'h0000_0001;

  cfg_dword_t dw_q [CFG_DWORDS];
  logic       pm_en, smb_en, pm_raw, smb_raw;

  for (genvar g = 0; g < CFG_DWORDS; g++) begin : g_dw
    if (g < FIRST_DW) begin : g_hdr
      assign dw_q[g] = '0;
    end else begin : g_dev
      localparam bit         IS_PM  = (g == PM_BASE_DW);
      localparam bit         IS_SMB = (g == SMB_BASE_DW);
      localparam bit         IS_SEN = (g == SMB_EN_DW);
      localparam cfg_dword_t KEEP   = IS_PM ? PM_KEEP : (IS_SMB ? SMB_KEEP :
                                      (IS_SEN ? SEN_KEEP : '1));
      localparam cfg_dword_t FORCE  = (IS_PM || IS_SMB) ? BASE_FORCE : '0;
      logic wr_sel;
      assign wr_sel = cfg_we && (cfg_waddr == g);
      cfg_dword_reg #(.KEEP(KEEP), .FORCE(FORCE), .RESET(FORCE)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_sel),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .q     (dw_q[g])
      );
    end
  end

  assign cfg_rdata = dw_q[cfg_raddr];
  assign pm_en     = dw_q[PM_EN_DW][PM_EN_POS];
  assign smb_en    = dw_q[SMB_EN_DW][SMB_EN_POS];

  iowin_match #(.IO_W(IO_W), .WIN_LOG2(PM_WIN_LOG2)) u_pm_match (
    .io_addr (io_addr),
    .base    (dw_q[PM_BASE_DW][IO_W-1:0]),
    .enable  (pm_en),
    .hit     (pm_raw)
  );

  iowin_match #(.IO_W(IO_W), .WIN_LOG2(SMB_WIN_LOG2)) u_smb_match (
    .io_addr (io_addr),
    .base    (dw_q[SMB_BASE_DW][IO_W-1:0]),
    .enable  (smb_en),
    .hit     (smb_raw)
  );

  // PM window has priority over the SMBus window
  assign pm_hit  = pm_raw;
  assign smb_hit = smb_raw && !pm_raw;

  assert_hits_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pm_hit, smb_hit}));
  assert_pm_base_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_q[PM_BASE_DW] & ~PM_KEEP) == BASE_FORCE);
  assert_smb_base_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_q[SMB_BASE_DW] & ~SMB_KEEP) == BASE_FORCE);
  assert_smb_en_nibble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_q[SMB_EN_DW] & ~SEN_KEEP) == '0);
  assert_pm_hit_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pm_hit |-> pm_en);
  assert_smb_hit_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    smb_hit |-> (smb_en && !pm_en || smb_en && !pm_raw));
  assert_hdr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_raddr < FIRST_DW) |-> (cfg_rdata == '0));
endmodule

// File: tb/tb_iowin_cfg_decoder.sv
`timescale 1ns/1ps
module tb_iowin_cfg_decoder;
  logic        clk, rst_n, cfg_we;
  logic [5:0]  cfg_waddr, cfg_raddr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [15:0] io_addr;
  logic        pm_hit, smb_hit;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_dw [64];

  iowin_cfg_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr),
    .cfg_rdata(cfg_rdata), .io_addr(io_addr), .pm_hit(pm_hit), .smb_hit(smb_hit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Model of a write, built from R2-R6 and R9
  task automatic model_write(input int idx, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] m;
    if (idx < 16 || be == 4'b0) return;
    m = exp_dw[idx];
    for (int k = 0; k < 4; k++) if (be[k]) m[k*8 +: 8] = d[k*8 +: 8];
    if (idx == 'h48/4) m = (m & 32'h0000FF80) | 32'h1;
    if (idx == 'h90/4) m = (m & 32'h0000FFF0) | 32'h1;
    if (idx == 'hD0/4) m[23:20] = 4'h0;
    exp_dw[idx] = m;
  endtask

  task automatic do_write(input int idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = 6'(idx); cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(idx, be, d);
  endtask

  task automatic read_check(input string req, input int idx);
    cfg_raddr = 6'(idx);
    #1;
    check(req, cfg_rdata, exp_dw[idx]);
  endtask

  task automatic hit_check(input logic [15:0] a);
    logic pe, se;
    @(negedge clk);
    io_addr = a;
    #1;
    pe = exp_dw[16][15] && (a[15:7] == exp_dw['h48/4][15:7]);
    se = exp_dw['hD0/4][16] && (a[15:4] == exp_dw['h90/4][15:4]) && !pe;
    check("R7 pm_hit", {31'b0, pm_hit}, {31'b0, pe});
    check("R8 smb_hit", {31'b0, smb_hit}, {31'b0, se});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_waddr = '0; cfg_be = '0;
    cfg_wdata = '0; cfg_raddr = '0; io_addr = 16'h0000;
    for (int i = 0; i < 64; i++) exp_dw[i] = 32'h0;
    exp_dw['h48/4] = 32'h1;
    exp_dw['h90/4] = 32'h1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents and idle hits
    for (int i = 0; i < 64; i++) read_check("R1 reset", i);
    hit_check(16'h0000);
    hit_check(16'h0080);

    // R9: header writes ignored
    for (int i = 0; i < 16; i++) begin
      do_write(i, 4'hF, 32'hDEAD_BEEF ^ i);
      read_check("R9 header", i);
    end

    // R2-R6: every device dword under every byte-enable pattern
    for (int i = 16; i < 64; i++) begin
      for (int b = 0; b < 16; b++) begin
        logic [31:0] d;
        d = 32'hA5C3_3C5A ^ (32'(i) * 32'h0101_0101 * 7) ^ (32'(b) * 32'h1111_1111);
        do_write(i, 4'(b), d);
        if (i == 'h48/4)      read_check("R2 pm base", i);
        else if (i == 'h90/4) read_check("R3 smb base", i);
        else if (i == 'hD0/4) read_check("R4 smb enable byte", i);
        else                  read_check("R5/R6 lanes", i);
      end
    end

    // Config A: disjoint windows, both enabled, full address sweep
    do_write(16, 4'hF, 32'h0000_8000);
    do_write('h48/4, 4'hF, 32'hFFFF_1234);
    do_write('h90/4, 4'h3, 32'h0000_12C7);
    do_write('hD0/4, 4'hF, 32'h00FF_0000);
    read_check("R2 pm base", 'h48/4);
    read_check("R3 smb base", 'h90/4);
    read_check("R4 smb enable byte", 'hD0/4);
    for (int a = 0; a < 65536; a++) hit_check(16'(a));

    // Config B: SMBus window inside PM window, PM wins (R8)
    do_write('h90/4, 4'h1, 32'h0000_0030);
    do_write('h90/4, 4'h2, 32'h0000_1200);
    read_check("R3 smb base", 'h90/4);
    for (int a = 'h1100; a < 'h1400; a++) hit_check(16'(a));

    // Config C: PM disabled through byte 0x41 only, SMBus visible (R7)
    do_write(16, 4'h2, 32'h0000_7F00);
    for (int a = 'h1180; a < 'h1300; a++) hit_check(16'(a));

    // Config D: SMBus disabled, PM moved (R8, R7)
    do_write('hD0/4, 4'h4, 32'h00FE_0000);
    do_write(16, 4'h2, 32'h0000_8000);
    do_write('h48/4, 4'h2, 32'h0000_3400);
    read_check("R2 pm base", 'h48/4);
    for (int a = 'h1180; a < 'h1300; a++) hit_check(16'(a));
    for (int a = 'h3380; a < 'h3500; a++) hit_check(16'(a));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule